// File: doc/BRIEF.md
# Dual-Address Two-Wire Port Slave

This block is the serial front end of a sixteen-line port expander. It oversamples the two-wire bus lines with the system clock and detects START and STOP conditions. It responds to two 7-bit slave addresses that share a 4-bit low field supplied by an external address decoder. The prefix 110 selects a mixed group: four output lines, four input lines and a 4-bit interrupt mask. The prefix 101 selects a group of eight output lines.

Writes to the mixed group load the output and mask registers. Writes to the eight-output group load all eight outputs. Reads return the levels present on the pins. For the mixed group, a read alternates the pin byte with a byte of change flags. Those flags come from a companion change-interrupt unit, and each data/flag pair takes a fresh sample.

The block drives that unit with a sample strobe, a read-active level and a STOP pulse. SDA is an open-drain enable: while `sda_oe` is high, the line is pulled low. `bus_rst_n` aborts a transfer without touching the port registers.

Top module: `i2cx_dual_slave`

## Requirements
- R1: After `rst`, `sda_oe` and `read_act` are 0, `a_drv` is 4'hF, `irq_mask` is 4'hF and `b_drv` is 8'hFF.
- R2: After START, the first byte is an address (bits 7:5 prefix, bits 4:1 = `addr_lo`, bit 0 = 1 for read). The block pulls SDA low in the ninth clock only for prefix 110 or 101 with a matching low field.
- R3: `sample_stb` pulses once, for one cycle, during the ACK of a matching address, for reads and writes alike. A non-matching address produces no pulse.
- R4: Each byte written to the 110 group is acknowledged. Its bits 0, 1, 6 and 7 go to `a_drv[0..3]`, and its bits 5:2 go to `irq_mask`.
- R5: Each byte written to the 101 group is acknowledged and loads all eight bits into `b_drv`.
- R6: In a 110-group read, byte 0 is `a_pins_i` as sampled at the address ACK. Byte 1 carries `chg_flags_i` as sampled at that same strobe, placed in bits 5:2, with all other bits 0.
- R7: A 110-group read longer than two bytes repeats the data/flags pair. The master ACK after each flag byte raises `sample_stb` again and resamples both pins and flags.
- R8: Every byte of a 101-group read is `b_pins_i` as sampled at the ACK just before that byte.
- R9: After the master NACKs a read byte, SDA stays released and no strobe is issued until the next START or STOP.
- R10: `read_act` rises at the ACK of a matching read address. It stays high until the next START, STOP or bus reset.
- R11: `stop_pulse` is high for exactly one cycle per STOP condition on the bus.
- R12: `bus_rst_n` low returns the interface to idle, with SDA released and `read_act` low, and keeps the output and mask registers. A later transfer is handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst_n | input | 1 | Active-low interface abort |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| addr_lo | input | 4 | Low four address bits from the decoder |
| a_pins_i | input | 8 | Pin levels of the mixed group |
| b_pins_i | input | 8 | Pin levels of the eight-output group |
| chg_flags_i | input | 4 | Change flags from the interrupt unit |
| a_drv | output | 4 | Mixed-group output registers (byte bits 0,1,6,7) |
| irq_mask | output | 4 | Interrupt mask register |
| b_drv | output | 8 | Eight-output group registers |
| sample_stb | output | 1 | Snapshot/clear strobe to the interrupt unit |
| read_act | output | 1 | A read is in progress |
| stop_pulse | output | 1 | One-cycle pulse on STOP |

## Verification
The addresses tried are random ones with a wrong prefix, the right prefix with a wrong low field, and both valid addresses. This tells apart decoding of the prefix, the low field and the R/W bit. Write data is random and goes to both groups, so any crossing between the output bits and the mask bits shows up.

Reads change the pins and the flags right after each strobe. A byte then matches only if it was captured at the intended ACK, not earlier and not later.

Three kinds of termination are exercised. A master NACK, a repeated START and a mid-byte bus abort each separate the ways the interface can fail to return to idle.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;

    localparam int BYTE_W = 8;
    localparam int LOW_W  = 4;
    localparam int PFX_W  = 3;
    localparam int CNT_W  = 4;

    localparam logic [PFX_W-1:0] PFX_A = 3'b110;
    localparam logic [PFX_W-1:0] PFX_B = 3'b101;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } bus_st_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic [3:0] a_outs_of(input logic [BYTE_W-1:0] b);
        return {b[7], b[6], b[1], b[0]};
    endfunction

    function automatic logic [3:0] mask_of(input logic [BYTE_W-1:0] b);
        return b[5:2];
    endfunction

    function automatic logic [BYTE_W-1:0] flag_byte(input logic [3:0] f);
        return {2'b00, f, 2'b00};
    endfunction

endpackage

// File: rtl/i2cx_line_cond.sv
module i2cx_line_cond
    import i2cx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
    logic scl_p, sda_p;
    logic scl_s, sda_s;

    assign scl_s = scl_sr[SYNC_STAGES-1];
    assign sda_s = sda_sr[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_i};
            sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_i};
            scl_p  <= scl_s;
            sda_p  <= sda_s;
        end
    end

    always_comb begin
        ev.rise  = scl_s & ~scl_p;
        ev.fall  = ~scl_s & scl_p;
        ev.start = scl_s & scl_p & sda_p & ~sda_s;
        ev.stop  = scl_s & scl_p & ~sda_p & sda_s;
        ev.sda   = sda_s;
    end
endmodule

// File: rtl/i2cx_port_regs.sv
module i2cx_port_regs
    import i2cx_pkg::*;
#(
    parameter logic [3:0]        A_OUT_RST = 4'hF,
    parameter logic [3:0]        MASK_RST  = 4'hF,
    parameter logic [BYTE_W-1:0] B_OUT_RST = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic [BYTE_W-1:0] wdata,
    output logic [3:0]        a_drv,
    output logic [3:0]        irq_mask,
    output logic [BYTE_W-1:0] b_drv
);
    always_ff @(posedge clk) begin
        if (rst) begin
            a_drv    <= A_OUT_RST;
            irq_mask <= MASK_RST;
            b_drv    <= B_OUT_RST;
        end else begin
            if (wr_a) begin
                a_drv    <= a_outs_of(wdata);
                irq_mask <= mask_of(wdata);
            end
            if (wr_b) begin
                b_drv <= wdata;
            end
        end
    end
endmodule

// File: rtl/i2cx_dual_slave.sv
module i2cx_dual_slave
    import i2cx_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [3:0]        A_OUT_RST   = 4'hF,
    parameter logic [3:0]        MASK_RST    = 4'hF,
    parameter logic [BYTE_W-1:0] B_OUT_RST   = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [LOW_W-1:0]  addr_lo,
    input  logic [BYTE_W-1:0] a_pins_i,
    input  logic [BYTE_W-1:0] b_pins_i,
    input  logic [3:0]        chg_flags_i,
    output logic [3:0]        a_drv,
    output logic [3:0]        irq_mask,
    output logic [BYTE_W-1:0] b_drv,
    output logic              sample_stb,
    output logic              read_act,
    output logic              stop_pulse
);
    bus_ev_t           ev;
    bus_st_e           st;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] sh, tx, snap_pins, next_byte;
    logic [3:0]        snap_flg;
    logic              sda_oe_q, is_rd, grp_b, odd, acked, rd_act_q;
    logic              hit_a, hit_b, stb_now, cap_b, wr_a_stb, wr_b_stb;
    logic              start_ev, stop_ev, byte_done;

    i2cx_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    assign start_ev  = ev.start;
    assign stop_ev   = ev.stop;
    assign byte_done = (bitcnt == CNT_W'(BYTE_W));
    assign hit_a     = (sh[7:5] == PFX_A) && (sh[4:1] == addr_lo);
    assign hit_b     = (sh[7:5] == PFX_B) && (sh[4:1] == addr_lo);

    always_comb begin
        stb_now = 1'b0;
        cap_b   = 1'b0;
        if (bus_rst_n && ev.rise) begin
            if (st == ST_AACK) begin
                stb_now = 1'b1;
            end else if (st == ST_RACK && !ev.sda) begin
                if (grp_b) cap_b = 1'b1;
                else if (odd) stb_now = 1'b1;
            end
        end
    end

    assign wr_a_stb = bus_rst_n && ev.fall && st == ST_WDATA && byte_done && !grp_b;
    assign wr_b_stb = bus_rst_n && ev.fall && st == ST_WDATA && byte_done && grp_b;

    always_comb begin
        if (grp_b || odd) next_byte = snap_pins;
        else next_byte = flag_byte(snap_flg);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            bitcnt    <= '0;
            sh        <= '0;
            tx        <= '0;
            snap_pins <= '0;
            snap_flg  <= '0;
            sda_oe_q  <= 1'b0;
            is_rd     <= 1'b0;
            grp_b     <= 1'b0;
            odd       <= 1'b0;
            acked     <= 1'b0;
            rd_act_q  <= 1'b0;
        end else if (!bus_rst_n || ev.stop) begin
            st       <= ST_IDLE;
            bitcnt   <= '0;
            sda_oe_q <= 1'b0;
            rd_act_q <= 1'b0;
        end else if (ev.start) begin
            st       <= ST_ADDR;
            bitcnt   <= '0;
            sda_oe_q <= 1'b0;
            rd_act_q <= 1'b0;
        end else begin
            if (stb_now) begin
                snap_pins <= grp_b ? b_pins_i : a_pins_i;
                snap_flg  <= chg_flags_i;
            end
            if (cap_b) begin
                snap_pins <= b_pins_i;
            end
            unique case (st)
                ST_ADDR, ST_WDATA: begin
                    if (ev.rise) begin
                        sh     <= {sh[BYTE_W-2:0], ev.sda};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (ev.fall && byte_done) begin
                        bitcnt <= '0;
                        if (st == ST_WDATA) begin
                            sda_oe_q <= 1'b1;
                            st       <= ST_WACK;
                        end else if (hit_a || hit_b) begin
                            sda_oe_q <= 1'b1;
                            is_rd    <= sh[0];
                            grp_b    <= hit_b;
                            st       <= ST_AACK;
                        end else begin
                            st <= ST_WAIT;
                        end
                    end
                end
                ST_AACK: begin
                    if (ev.rise && is_rd) begin
                        rd_act_q <= 1'b1;
                    end
                    if (ev.fall) begin
                        if (is_rd) begin
                            tx       <= snap_pins;
                            sda_oe_q <= ~snap_pins[BYTE_W-1];
                            odd      <= 1'b0;
                            st       <= ST_RDATA;
                        end else begin
                            sda_oe_q <= 1'b0;
                            st       <= ST_WDATA;
                        end
                    end
                end
                ST_WACK: begin
                    if (ev.fall) begin
                        sda_oe_q <= 1'b0;
                        st       <= ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (ev.rise) begin
                        bitcnt <= bitcnt + 1'b1;
                    end else if (ev.fall) begin
                        if (byte_done) begin
                            bitcnt   <= '0;
                            sda_oe_q <= 1'b0;
                            st       <= ST_RACK;
                        end else begin
                            sda_oe_q <= ~tx[BYTE_W-2];
                            tx       <= {tx[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                ST_RACK: begin
                    if (ev.rise) begin
                        acked <= ~ev.sda;
                    end else if (ev.fall) begin
                        if (acked) begin
                            tx       <= next_byte;
                            sda_oe_q <= ~next_byte[BYTE_W-1];
                            odd      <= ~odd;
                            st       <= ST_RDATA;
                        end else begin
                            sda_oe_q <= 1'b0;
                            st       <= ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    i2cx_port_regs #(
        .A_OUT_RST (A_OUT_RST),
        .MASK_RST  (MASK_RST),
        .B_OUT_RST (B_OUT_RST)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_a     (wr_a_stb),
        .wr_b     (wr_b_stb),
        .wdata    (sh),
        .a_drv    (a_drv),
        .irq_mask (irq_mask),
        .b_drv    (b_drv)
    );

    assign sda_oe     = sda_oe_q;
    assign read_act   = rd_act_q;
    assign sample_stb = stb_now;
    assign stop_pulse = ev.stop;
endmodule

// File: rtl/i2cx_dual_slave_chk.sv
module i2cx_dual_slave_chk
    import i2cx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_rst_n,
    input logic              start_ev,
    input logic              stop_ev,
    input logic              sample_stb,
    input logic              stop_pulse,
    input logic              sda_oe,
    input logic              read_act,
    input logic [3:0]        irq_mask,
    input logic [BYTE_W-1:0] b_drv,
    input logic              wr_a_stb,
    input logic              wr_b_stb,
    input bus_st_e           st
);
    assert_stb_single_R3: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> !sample_stb);

    assert_stop_single_R11: assert property (@(posedge clk) disable iff (rst)
        stop_pulse |=> !stop_pulse);

    assert_abort_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !bus_rst_n |=> (!sda_oe && !read_act));

    assert_mask_only_on_write_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(irq_mask) |-> $past(wr_a_stb));

    assert_b_only_on_write_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(b_drv) |-> $past(wr_b_stb));

    assert_readact_end_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(read_act) |-> $past(start_ev || stop_ev || !bus_rst_n));

    assert_wait_released_R9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT) |-> !sda_oe);

    assert_wait_no_stb_R9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT) |-> !sample_stb);
endmodule

bind i2cx_dual_slave i2cx_dual_slave_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_rst_n  (bus_rst_n),
    .start_ev   (start_ev),
    .stop_ev    (stop_ev),
    .sample_stb (sample_stb),
    .stop_pulse (stop_pulse),
    .sda_oe     (sda_oe),
    .read_act   (read_act),
    .irq_mask   (irq_mask),
    .b_drv      (b_drv),
    .wr_a_stb   (wr_a_stb),
    .wr_b_stb   (wr_b_stb),
    .st         (st)
);

// File: tb/i2cx_dual_slave_tb.sv
module i2cx_dual_slave_tb;
    localparam int Q = 8;
    localparam logic [3:0] LO = 4'b1010;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst, bus_rst_n, scl, m_low;
    logic       sda_oe, read_act, sample_stb, stop_pulse;
    logic [7:0] a_pins, b_pins, b_drv;
    logic [3:0] flags, a_drv, irq_mask;
    wire        sda_line = !(m_low || sda_oe);

    int total = 0, fails = 0;
    int stb_cnt = 0, stop_cnt = 0, stop_hi = 0, exp_stops = 0;
    logic stop_prev = 1'b0;

    logic [3:0] exp_a = 4'hF, exp_m = 4'hF;
    logic [7:0] exp_b = 8'hFF;

    i2cx_dual_slave u_dut (
        .clk         (clk),
        .rst         (rst),
        .bus_rst_n   (bus_rst_n),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .sda_oe      (sda_oe),
        .addr_lo     (LO),
        .a_pins_i    (a_pins),
        .b_pins_i    (b_pins),
        .chg_flags_i (flags),
        .a_drv       (a_drv),
        .irq_mask    (irq_mask),
        .b_drv       (b_drv),
        .sample_stb  (sample_stb),
        .read_act    (read_act),
        .stop_pulse  (stop_pulse)
    );

    always @(posedge clk) begin
        if (sample_stb) stb_cnt++;
        if (stop_pulse && !stop_prev) stop_cnt++;
        if (stop_pulse) stop_hi++;
        stop_prev <= stop_pulse;
    end

    function automatic logic [7:0] f_byte(input logic [3:0] f);
        return {2'b00, f, 2'b00};
    endfunction
    function automatic logic [3:0] f_aout(input logic [7:0] b);
        return {b[7], b[6], b[1], b[0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        m_low = 1'b0; wt(Q);
        scl = 1'b1;   wt(Q);
        m_low = 1'b1; wt(Q);
        scl = 1'b0;
    endtask

    task automatic m_stop();
        m_low = 1'b1; wt(Q);
        scl = 1'b1;   wt(Q);
        m_low = 1'b0; wt(2*Q);
        exp_stops++;
    endtask

    task automatic bit_io(input logic bo, output logic bi);
        wt(Q); m_low = !bo;
        wt(Q); scl = 1'b1;
        wt(Q); bi = sda_line;
        wt(Q); scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic d;
        for (int i = 7; i >= 0; i--) bit_io(b[i], d);
        bit_io(1'b1, d);
        ack = !d;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic mack);
        logic d;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, d);
            b[i] = d;
        end
        bit_io(!mack, d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog R1..: actual=timeout expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic       ack, d;
        logic [7:0] rb, wb, p0, p1, p2;
        logic [3:0] f0, f1;
        int         s0;
        void'($urandom(32'h1C2D3E4F));
        rst = 1'b1; bus_rst_n = 1'b1; scl = 1'b1; m_low = 1'b0;
        a_pins = 8'h00; b_pins = 8'h00; flags = 4'h0;
        wt(5); rst = 1'b0; wt(5);

        // R1 reset state
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 read_act", read_act, 0);
        chk("R1 a_drv", a_drv, 4'hF);
        chk("R1 irq_mask", irq_mask, 4'hF);
        chk("R1 b_drv", b_drv, 8'hFF);

        // R2 R3 R4 mixed-group write, several bytes
        s0 = stb_cnt;
        m_start();
        send_byte({3'b110, LO, 1'b0}, ack);
        chk("R2 ack group A write", ack, 1);
        chk("R3 strobe on write addr", stb_cnt, s0 + 1);
        for (int k = 0; k < 3; k++) begin
            wb = 8'($urandom);
            send_byte(wb, ack);
            exp_a = f_aout(wb); exp_m = wb[5:2];
            chk("R4 data ack", ack, 1);
            chk("R4 a_drv", a_drv, exp_a);
            chk("R4 irq_mask", irq_mask, exp_m);
            chk("R5 b_drv untouched", b_drv, exp_b);
        end
        m_stop();

        // R5 eight-output group write
        m_start();
        send_byte({3'b101, LO, 1'b0}, ack);
        chk("R2 ack group B write", ack, 1);
        for (int k = 0; k < 2; k++) begin
            wb = 8'($urandom);
            send_byte(wb, ack);
            exp_b = wb;
            chk("R5 data ack", ack, 1);
            chk("R5 b_drv", b_drv, exp_b);
            chk("R4 a_drv untouched", a_drv, exp_a);
        end
        m_stop();

        // R2 R3 non-matching addresses
        for (int k = 0; k < 5; k++) begin
            logic [2:0] p;
            logic [3:0] lo;
            p = 3'($urandom);
            while (p == 3'b110 || p == 3'b101) p = 3'($urandom);
            lo = 4'($urandom);
            if (k == 4) begin p = 3'b110; lo = LO ^ 4'b0001; end
            s0 = stb_cnt;
            m_start();
            send_byte({p, lo, 1'($urandom)}, ack);
            chk("R2 no ack for foreign address", ack, 0);
            chk("R3 no strobe for foreign address", stb_cnt, s0);
            m_stop();
            chk("R4 regs after foreign", {a_drv, irq_mask}, {exp_a, exp_m});
        end

        // R6 R7 R9 R10 mixed-group long read
        p0 = 8'($urandom); f0 = 4'($urandom);
        a_pins = p0; flags = f0;
        s0 = stb_cnt;
        m_start();
        send_byte({3'b110, LO, 1'b1}, ack);
        chk("R2 ack group A read", ack, 1);
        chk("R10 read_act after addr ack", read_act, 1);
        chk("R3 strobe on read addr", stb_cnt, s0 + 1);
        p1 = 8'($urandom); f1 = 4'($urandom);
        a_pins = p1; flags = f1;
        recv_byte(rb, 1'b1);
        chk("R6 first byte pins", rb, p0);
        recv_byte(rb, 1'b1);
        chk("R6 second byte flags", rb, f_byte(f0));
        chk("R7 strobe per pair", stb_cnt, s0 + 2);
        p2 = 8'($urandom);
        a_pins = p2; flags = 4'($urandom);
        recv_byte(rb, 1'b1);
        chk("R7 third byte resampled pins", rb, p1);
        recv_byte(rb, 1'b0);
        chk("R7 fourth byte resampled flags", rb, f_byte(f1));
        bit_io(1'b1, d);
        chk("R9 SDA released after NACK", d, 1);
        bit_io(1'b1, d);
        chk("R9 SDA still released", d, 1);
        chk("R9 no strobe after NACK", stb_cnt, s0 + 2);
        chk("R10 read_act held until STOP", read_act, 1);
        m_stop();
        chk("R10 read_act cleared by STOP", read_act, 0);

        // R8 eight-output group read
        p0 = 8'($urandom); b_pins = p0;
        m_start();
        send_byte({3'b101, LO, 1'b1}, ack);
        chk("R2 ack group B read", ack, 1);
        p1 = 8'($urandom); b_pins = p1;
        recv_byte(rb, 1'b1);
        chk("R8 byte0", rb, p0);
        p2 = 8'($urandom); b_pins = p2;
        recv_byte(rb, 1'b1);
        chk("R8 byte1", rb, p1);
        b_pins = 8'($urandom);
        recv_byte(rb, 1'b0);
        chk("R8 byte2", rb, p2);
        m_stop();

        // R10 repeated START ends the read
        m_start();
        send_byte({3'b110, LO, 1'b1}, ack);
        recv_byte(rb, 1'b0);
        chk("R10 read_act before repeated START", read_act, 1);
        m_start();
        wt(4);
        chk("R10 read_act cleared by repeated START", read_act, 0);
        send_byte({3'b110, LO, 1'b0}, ack);
        chk("R2 ack after repeated START", ack, 1);
        m_stop();

        // R12 abort in mid-read while SDA is driven low
        a_pins = 8'h00;
        m_start();
        send_byte({3'b110, LO, 1'b1}, ack);
        bit_io(1'b1, d);
        bit_io(1'b1, d);
        chk("R6 zero pins drive low", d, 0);
        bus_rst_n = 1'b0; wt(3);
        chk("R12 SDA released on abort", sda_oe, 0);
        chk("R12 read_act low on abort", read_act, 0);
        bus_rst_n = 1'b1; wt(2);
        chk("R12 registers kept", {a_drv, irq_mask, b_drv}, {exp_a, exp_m, exp_b});
        m_stop();
        m_start();
        send_byte({3'b101, LO, 1'b0}, ack);
        chk("R12 ack after abort", ack, 1);
        wb = 8'($urandom);
        send_byte(wb, ack);
        exp_b = wb;
        chk("R12 write after abort", b_drv, exp_b);
        m_stop();

        // R4 R5 random mixed writes
        for (int k = 0; k < 6; k++) begin
            logic g;
            g = 1'($urandom);
            m_start();
            send_byte({g ? 3'b101 : 3'b110, LO, 1'b0}, ack);
            wb = 8'($urandom);
            send_byte(wb, ack);
            if (g) exp_b = wb;
            else begin exp_a = f_aout(wb); exp_m = wb[5:2]; end
            m_stop();
            chk("R4 random a_drv", a_drv, exp_a);
            chk("R4 random irq_mask", irq_mask, exp_m);
            chk("R5 random b_drv", b_drv, exp_b);
        end

        // R11 one pulse per STOP, one cycle wide
        chk("R11 stop count", stop_cnt, exp_stops);
        chk("R11 stop width", stop_hi, exp_stops);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule